// File: doc/BRIEF.md
# Clock Rate and Enable Controller

This block turns one free-running oscillator clock into clock-enable strobes for a CPU core and five peripherals: timer 0, timer 1, the UART, the watchdog and the two-wire controller. Nothing is muxed or gated. Every consumer stays on the oscillator clock and advances only in cycles where its strobe is high.

A global mode bit sets the shared rate:

- In standard mode the strobes run at half the oscillator rate.
- In double-speed mode they are high on every cycle.

Each peripheral has a select bit. When it is set, that peripheral stays at half rate whatever the global mode. A change to the mode or to a select bit waits for the next half-rate boundary, so no strobe is ever cut short or repeated.

A small register port gives software four byte registers:

- the clock-control register;
- the loop control/status register, which holds the loop enable, a reset-hold bit, the two low R-divider bits and a read-only lock flag;
- the loop N divider;
- the upper R-divider bits.

The divider values leave the block as whole words for the analog loop. The register port is a plain control interface with single-cycle writes and combinational reads. It has no handshake.

Top module: `clock_rate_ctrl`

## Requirements
- R1: Register addresses are 0 clock-control, 1 loop control, 2 N divider, 3 R upper bits. In the cycle after a reset cycle, address 0 reads `{7'b0, nv_fast}`, address 1 reads 8'h08, and addresses 2 and 3 read 0. A synchronous reset, active while `rst_n` is low, loads bit 0 of clock-control from `nv_fast`.
- R2: A free half-rate strobe is high in the first cycle after reset release and in every second cycle after that. With clock-control bit 0 clear, `core_en` and `per_en` equal this strobe.
- R3: With clock-control bit 0 set, `core_en` and `per_en` are high in every cycle.
- R4: `dev_en[0..4]` belong to timer 0, timer 1, the UART, the watchdog and the two-wire controller. Their select bits are clock-control bits 1, 2, 4, 6 and 7. A peripheral whose select bit is set follows the half-rate strobe. A peripheral whose select bit is clear follows `per_en`.
- R5: A written mode or select value takes effect only in the cycle after a half-rate strobe. `core_en` is never low in two consecutive cycles.
- R6: These bits are not writable and read 0:
  - bits 5 and 3 of clock-control;
  - bits 5, 4 and 2 of loop control;
  - bit 7 of the N divider.
- R7: Bit 0 of loop control is read-only. It reads 1 only while loop bit 1 (enable) is 1, loop bit 3 (hold) is 0, and `lock_in` has been high for the two synchronizer cycles.
- R8: The divider and control outputs are:
  - `loop_ndiv` is N-register bits 6:0;
  - `loop_rdiv` is {R-upper register, loop control bits 7:6};
  - `loop_en` is loop bit 1;
  - `loop_hold` is loop bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nv_fast | input | 1 | Nonvolatile reset value of the double-speed mode bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| lock_in | input | 1 | Asynchronous lock indication from the loop |
| core_en | output | 1 | CPU core clock enable |
| per_en | output | 1 | Global peripheral clock enable |
| dev_en | output | 5 | Per-peripheral clock enables |
| loop_en | output | 1 | Loop enable |
| loop_hold | output | 1 | Loop reset-hold |
| loop_ndiv | output | 7 | N divider value |
| loop_rdiv | output | 10 | R divider value |

## Verification
The hardest case to reach is a mode or select write that lands at either phase of the half-rate strobe. If the new setting were applied at the wrong phase, a strobe would be cut short or repeated. The bench sweeps every combination of mode and select bits, so each write lands at both phases, and it keeps checking for two consecutive low `core_en` cycles across every transition. A reference phase counter in the bench, driven only by `rst_n`, supplies the expected strobe pattern.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int NDEV = 5;
  localparam logic [1:0] ADDR_CLK  = 2'd0;
  localparam logic [1:0] ADDR_LOOP = 2'd1;
  localparam logic [1:0] ADDR_NDIV = 2'd2;
  localparam logic [1:0] ADDR_RHI  = 2'd3;
  localparam logic [7:0] CLK_WMASK  = 8'hD7;
  localparam logic [7:0] LOOP_WMASK = 8'hCA;
  localparam logic [7:0] LOOP_RST   = 8'h08;
  localparam int LOOP_EN_BIT   = 1;
  localparam int LOOP_HOLD_BIT = 3;

  function automatic int dev_pos(input int idx);
    case (idx)
      0: dev_pos = 1;
      1: dev_pos = 2;
      2: dev_pos = 4;
      3: dev_pos = 6;
      default: dev_pos = 7;
    endcase
  endfunction
endpackage

// File: rtl/clkctl_sync.sv
module clkctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/clkctl_strobe.sv
module clkctl_strobe #(
  parameter int NDEV = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_fast,
  input  logic            fast_req,
  input  logic [NDEV-1:0] sel_req,
  output logic            core_en,
  output logic            per_en,
  output logic [NDEV-1:0] dev_en
);
  logic            phase_q;
  logic            eff_fast_q;
  logic [NDEV-1:0] eff_sel_q;
  logic            glob_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= 1'b0;
      eff_fast_q <= cfg_fast;
      eff_sel_q  <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        eff_fast_q <= fast_req;
        eff_sel_q  <= sel_req;
      end
    end
  end

  assign glob_en = eff_fast_q | phase_q;
  assign core_en = glob_en;
  assign per_en  = glob_en;

  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    assign dev_en[i] = eff_sel_q[i] ? phase_q : glob_en;
  end

  assert_std_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && !eff_fast_q && !fast_req) |=> !core_en);
  assert_fast_continuous_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_fast_q && fast_req) |=> core_en);
  assert_no_double_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> core_en);
  assert_mode_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(eff_fast_q) |-> $past(phase_q));
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
#(
  parameter int NDIV_W = 7,
  parameter int RDIV_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fast,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              lock_s,
  output logic [7:0]        rdata,
  output logic [7:0]        clk_reg,
  output logic              loop_en,
  output logic              loop_hold,
  output logic [NDIV_W-1:0] n_div,
  output logic [RDIV_W-1:0] r_div
);
  localparam int RHI_W = RDIV_W - 2;

  logic [7:0]        ctl_q;
  logic [7:0]        loop_q;
  logic [NDIV_W-1:0] n_q;
  logic [RHI_W-1:0]  rhi_q;
  logic              lock_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= {7'b0, cfg_fast};
      loop_q <= LOOP_RST;
      n_q    <= '0;
      rhi_q  <= '0;
    end else if (wr) begin
      case (addr)
        ADDR_CLK:  ctl_q  <= wdata & CLK_WMASK;
        ADDR_LOOP: loop_q <= wdata & LOOP_WMASK;
        ADDR_NDIV: n_q    <= wdata[NDIV_W-1:0];
        default:   rhi_q  <= wdata[RHI_W-1:0];
      endcase
    end
  end

  assign lock_rd = loop_q[LOOP_EN_BIT] & ~loop_q[LOOP_HOLD_BIT] & lock_s;

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CLK:  rdata = ctl_q;
      ADDR_LOOP: rdata = {loop_q[7:1], lock_rd};
      ADDR_NDIV: rdata[NDIV_W-1:0] = n_q;
      default:   rdata[RHI_W-1:0]  = rhi_q;
    endcase
  end

  assign clk_reg   = ctl_q;
  assign loop_en   = loop_q[LOOP_EN_BIT];
  assign loop_hold = loop_q[LOOP_HOLD_BIT];
  assign n_div     = n_q;
  assign r_div     = {rhi_q, loop_q[7:6]};

  assert_ndiv_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_NDIV) |=> n_div == $past(wdata[NDIV_W-1:0]));
  assert_reserved_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_CLK) |=> (clk_reg[5] == 1'b0 && clk_reg[3] == 1'b0));
endmodule

// File: rtl/clock_rate_ctrl.sv
module clock_rate_ctrl
  import clkctl_pkg::*;
#(
  parameter int NDIV_W      = 7,
  parameter int RDIV_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nv_fast,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              lock_in,
  output logic              core_en,
  output logic              per_en,
  output logic [NDEV-1:0]   dev_en,
  output logic              loop_en,
  output logic              loop_hold,
  output logic [NDIV_W-1:0] loop_ndiv,
  output logic [RDIV_W-1:0] loop_rdiv
);
  logic            lock_s;
  logic [7:0]      clk_reg;
  logic [NDEV-1:0] sel_req;

  clkctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(lock_in), .d_out(lock_s)
  );

  clkctl_regs #(.NDIV_W(NDIV_W), .RDIV_W(RDIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_fast(nv_fast), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .lock_s(lock_s), .rdata(reg_rdata), .clk_reg(clk_reg),
    .loop_en(loop_en), .loop_hold(loop_hold), .n_div(loop_ndiv), .r_div(loop_rdiv)
  );

  for (genvar i = 0; i < NDEV; i++) begin : g_sel
    assign sel_req[i] = clk_reg[dev_pos(i)];
  end

  clkctl_strobe #(.NDEV(NDEV)) u_strobe (
    .clk(clk), .rst_n(rst_n), .cfg_fast(nv_fast), .fast_req(clk_reg[0]),
    .sel_req(sel_req), .core_en(core_en), .per_en(per_en), .dev_en(dev_en)
  );

  assert_lock_needs_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_LOOP && reg_rdata[0]) |-> (lock_s && loop_en && !loop_hold));
endmodule

// File: tb/tb_clock_rate_ctrl.sv
module tb_clock_rate_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nv_fast = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       lock_in = 1'b0;
  logic       core_en, per_en, loop_en, loop_hold;
  logic [4:0] dev_en;
  logic [6:0] loop_ndiv;
  logic [9:0] loop_rdiv;

  int total = 0;
  int bad = 0;
  logic ph = 1'b0;
  logic mon_on = 1'b0;
  logic prev_low = 1'b0;
  int dbl_low = 0;

  clock_rate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .nv_fast(nv_fast), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lock_in(lock_in), .core_en(core_en), .per_en(per_en), .dev_en(dev_en),
    .loop_en(loop_en), .loop_hold(loop_hold), .loop_ndiv(loop_ndiv),
    .loop_rdiv(loop_rdiv)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) ph <= rst_n ? ~ph : 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (!core_en && prev_low) dbl_low++;
      prev_low <= !core_en;
    end else begin
      prev_low <= 1'b0;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset(input logic fast);
    mon_on = 1'b0;
    @(negedge clk);
    nv_fast = fast; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    do_reset(1'b0);
    // R1 reset values
    rd(2'd0, v); chk(v == 8'h00, "R1 clk reg", v, 8'h00);
    rd(2'd1, v); chk(v == 8'h08, "R1 loop reg", v, 8'h08);
    rd(2'd2, v); chk(v == 8'h00, "R1 ndiv reg", v, 8'h00);
    rd(2'd3, v); chk(v == 8'h00, "R1 rhi reg", v, 8'h00);
    chk(loop_hold == 1'b1 && loop_en == 1'b0, "R1 loop outputs", {loop_hold, loop_en}, 2'b10);
    mon_on = 1'b1;
    // R2 standard mode after reset
    for (int c = 0; c < 6; c++) begin
      #1;
      chk(core_en == ph && per_en == ph, "R2 std strobe", {core_en, per_en}, {ph, ph});
      @(negedge clk);
    end
    // R2 R3 R4 sweep of modes and selects
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 32; s++) begin
        logic [4:0] sb;
        sb = 5'(s);
        wr(2'd0, {sb[4], sb[3], 1'b0, sb[2], 1'b0, sb[1], sb[0], m[0]});
        repeat (3) @(negedge clk);
        for (int c = 0; c < 4; c++) begin
          logic ge;
          logic [4:0] de;
          #1;
          ge = m[0] ? 1'b1 : ph;
          for (int i = 0; i < 5; i++) de[i] = sb[i] ? ph : ge;
          chk(core_en == ge && per_en == ge, m[0] ? "R3 fast strobe" : "R2 std strobe",
              {core_en, per_en}, {ge, ge});
          chk(dev_en == de, "R4 peripheral enables", dev_en, de);
          @(negedge clk);
        end
      end
    end
    // R5 no double low across all transitions
    chk(dbl_low == 0, "R5 double low count", dbl_low, 0);
    // R6 reserved bits, R8 outputs
    wr(2'd0, 8'hFF); rd(2'd0, v); chk(v == 8'hD7, "R6 clk reserved", v, 8'hD7);
    wr(2'd1, 8'hFF); rd(2'd1, v); chk(v == 8'hCA, "R6 loop reserved", v, 8'hCA);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk(v == 8'h7F, "R6 ndiv reserved", v, 8'h7F);
    wr(2'd3, 8'hA5); rd(2'd3, v); chk(v == 8'hA5, "R8 rhi readback", v, 8'hA5);
    chk(loop_ndiv == 7'h7F, "R8 ndiv out", loop_ndiv, 7'h7F);
    chk(loop_rdiv == 10'h297, "R8 rdiv out", loop_rdiv, 10'h297);
    chk(loop_en && loop_hold, "R8 en hold out", {loop_en, loop_hold}, 2'b11);
    wr(2'd2, 8'h35); chk(loop_ndiv == 7'h35, "R8 ndiv out2", loop_ndiv, 7'h35);
    wr(2'd1, 8'h42); chk(loop_rdiv == 10'h295, "R8 rdiv low bits", loop_rdiv, 10'h295);
    // R7 lock flag
    lock_in = 1'b1; repeat (3) @(negedge clk);
    rd(2'd1, v); chk(v[0] == 1'b1, "R7 lock set", v[0], 1);
    wr(2'd1, 8'h0A); repeat (2) @(negedge clk);
    rd(2'd1, v); chk(v[0] == 1'b0, "R7 lock held", v[0], 0);
    wr(2'd1, 8'h00); rd(2'd1, v); chk(v[0] == 1'b0, "R7 lock disabled", v[0], 0);
    wr(2'd1, 8'h02); lock_in = 1'b0; repeat (3) @(negedge clk);
    rd(2'd1, v); chk(v[0] == 1'b0, "R7 lock lost", v[0], 0);
    wr(2'd1, 8'h03); rd(2'd1, v); chk(v == 8'h02, "R7 lock write ignored", v, 8'h02);
    // R1 reset with nonvolatile fast bit
    do_reset(1'b1);
    rd(2'd0, v); chk(v == 8'h01, "R1 nv fast reset", v, 8'h01);
    for (int c = 0; c < 4; c++) begin
      #1; chk(core_en == 1'b1, "R3 fast after reset", core_en, 1);
      @(negedge clk);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule